// File: doc/BRIEF.md
# Frame-Delayed Sprite Attribute Store with Sprite Colour Path

This block holds two sprite attribute memories of 256 bytes each. At any time one is the display bank, which the sprite renderer reads, and the other is the pending bank, which the processor writes and reads back. After the sprites of the last visible scanline have been drawn, the two banks swap roles. The bank that has just been shown becomes the new pending bank and reads as all zeros. Because the renderer always shows what the processor wrote during the previous frame, sprites trail the background by one frame.

The block also handles the sprite pixel path. It drops sprite pixels that fall near the left or right screen edge. For each pixel that survives, it looks up a palette entry, places the result in the upper half of a 128-entry colour table, and fetches a byte from a colour ROM built from two 4-bit PROMs. It unpacks that byte into 8-bit red, green and blue.

Top module: `sprite_frame_buffer`

## Requirements
- R1: The processor port writes and reads only the pending bank. The renderer port reads only the display bank. A processor write never changes what the renderer reads before the next swap.
- R2: The banks swap roles on a clock edge where `line_done` is high and `line_num` equals 239. With any other `line_num`, or with `line_done` low, the roles do not change.
- R3: After a swap, every address of the new pending bank reads 0. The renderer sees, at every address, the data last written to the bank that was pending before the swap.
- R4: A processor write on the same edge as a swap is applied after the clear. It lands in the new pending bank and is visible on the next cycle, while all other addresses of that bank read 0.
- R5: After reset, every address reads 0 on both the processor and the renderer ports.
- R6: `spr_valid` is the value of `pix_valid` from the previous cycle. It is forced low when that pixel's x was below 8 or at or above 250.
- R7: `pal_addr` is `{pix_grp[2:0], pix_val[1:0]}` (group times 4, OR pixel, 5 bits). `spr_cidx` is `{1'b1, pal_data[5:0]}`, registered with `spr_valid`, so sprite colours use entries 64 to 127.
- R8: `rom_addr` is `{1'b1, cidx}`: colour-table bit 7 is forced high.
- R9: The ROM byte is `{rom_hi, rom_lo}`. Red is byte bits 0,1,2 as red bits 2,1,0 (reversed). Green is byte bits 3,4,5 as green bits 2,1,0. Blue is byte bits 6,7 as blue bits 1,0.
- R10: `spr_rgb` is `{R8, G8, B8}`. The 3-bit fields widen to 8 bits as `{c,c,c[2:1]}` and the 2-bit field as `{b,b,b,b}`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 8 | Processor byte address into the pending bank |
| cpu_wdata | input | 8 | Processor write data |
| cpu_we | input | 1 | Processor write strobe |
| cpu_rdata | output | 8 | Pending-bank read data (combinational) |
| rend_addr | input | 8 | Renderer byte address into the display bank |
| rend_data | output | 8 | Display-bank read data (combinational) |
| line_num | input | 9 | Current scanline number |
| line_done | input | 1 | End-of-scanline strobe, one cycle |
| pix_valid | input | 1 | A sprite pixel is presented |
| pix_x | input | 8 | Screen x of the sprite pixel |
| pix_grp | input | 3 | Sprite palette group |
| pix_val | input | 2 | 2-bit sprite pixel value |
| pal_addr | output | 5 | Palette RAM address for the presented pixel |
| pal_data | input | 6 | Palette RAM entry returned for `pal_addr` |
| rom_addr | output | 8 | Colour ROM address (bit 7 always set) |
| rom_hi | input | 4 | High-nibble PROM data |
| rom_lo | input | 4 | Low-nibble PROM data |
| spr_valid | output | 1 | Registered pixel-valid after clipping |
| spr_cidx | output | 7 | Registered colour-table index |
| spr_rgb | output | 24 | Registered RGB, red in the top byte |

## Verification
The assertions watch every cycle for these properties: the role bit flips only on the swap line, the new pending bank reads zero right after a swap, clipped pixels never produce a valid output, and every valid output carries an upper-table colour index. Only the bench's scenarios can show the rest. These include that a full bank of writes survives the swap intact for the renderer, that a write in the swap cycle survives the clear, and that the bit-reversed ROM unpacking and replication match for every group, pixel and x position.

// File: rtl/sprite_fb_pkg.sv
// Package: shared constants and the colour-ROM byte unpacking used by the
// sprite frame buffer. Assumes a 3/3/2 packed ROM byte with reversed fields.
package sprite_fb_pkg;

    localparam int RGB_W = 24;

    // Widen a 3-bit colour field to 8 bits by bit replication.
    function automatic logic [7:0] widen3(input logic [2:0] c);
        return {c, c, c[2:1]};
    endfunction

    // Widen a 2-bit colour field to 8 bits by bit replication.
    function automatic logic [7:0] widen2(input logic [1:0] c);
        return {c, c, c, c};
    endfunction

endpackage

// File: rtl/sprbuf_bank.sv
// One sprite attribute bank: a byte array plus a per-address live flag.
// A clear drops every live flag in one cycle, so cleared bytes read as zero
// without rewriting the array. A write in the same cycle as a clear is kept.
// Assumes a single write port and a single combinational read port.
module sprbuf_bank #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0]    mem [DEPTH];
    logic [DEPTH-1:0] live;
    logic [DEPTH-1:0] live_nxt;

    // Store write data; no reset needed since live flags gate reads.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Next live flags: a clear comes first, then the write is marked.
    always_comb begin
        live_nxt = clr ? '0 : live;
        if (we) live_nxt[waddr] = 1'b1;
    end

    // Register live flags, all dead after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) live <= '0;
        else        live <= live_nxt;
    end

    // Read returns zero for any address not written since the last clear.
    assign rdata = live[raddr] ? mem[raddr] : '0;
endmodule

// File: rtl/spr_color_decode.sv
// Unpacks a colour ROM byte assembled from two nibble PROMs into 24-bit RGB.
// Red, green and blue fields are stored bit-reversed at bits 0-2, 3-5, 6-7.
module spr_color_decode
    import sprite_fb_pkg::*;
(
    input  logic [3:0]       nib_hi,
    input  logic [3:0]       nib_lo,
    output logic [RGB_W-1:0] rgb
);
    logic [7:0] rom_byte;
    logic [2:0] r3, g3;
    logic [1:0] b2;

    // Join nibbles and reverse each field into natural bit order.
    always_comb begin
        rom_byte = {nib_hi, nib_lo};
        r3  = {rom_byte[0], rom_byte[1], rom_byte[2]};
        g3  = {rom_byte[3], rom_byte[4], rom_byte[5]};
        b2  = {rom_byte[6], rom_byte[7]};
        rgb = {widen3(r3), widen3(g3), widen2(b2)};
    end
endmodule

// File: rtl/spr_pixel_path.sv
// Sprite pixel path: edge clipping, palette addressing, upper-bank colour
// index, ROM address with bit 7 forced, and a single output register stage.
// Assumes palette and ROM return data in the same cycle as their address.
module spr_pixel_path
    import sprite_fb_pkg::*;
#(
    parameter int XW       = 8,
    parameter int SCREEN_W = 256,
    parameter int CLIP_L   = 8,
    parameter int CLIP_R   = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_valid,
    input  logic [XW-1:0]    pix_x,
    input  logic [2:0]       pix_grp,
    input  logic [1:0]       pix_val,
    output logic [4:0]       pal_addr,
    input  logic [5:0]       pal_data,
    output logic [7:0]       rom_addr,
    input  logic [3:0]       rom_hi,
    input  logic [3:0]       rom_lo,
    output logic             spr_valid,
    output logic [6:0]       spr_cidx,
    output logic [RGB_W-1:0] spr_rgb
);
    localparam int X_LIMIT = SCREEN_W - CLIP_R;

    logic             in_window;
    logic [6:0]       cidx;
    logic [RGB_W-1:0] rgb;

    // Keep only pixels inside the visible sprite window.
    assign in_window = (int'(pix_x) >= CLIP_L) && (int'(pix_x) < X_LIMIT);

    // Palette address and colour-table index in the sprite half.
    always_comb begin
        pal_addr = {pix_grp, pix_val} & 5'h1F;
        cidx     = {1'b1, pal_data};
        rom_addr = {1'b1, cidx};
    end

    spr_color_decode u_dec (
        .nib_hi (rom_hi),
        .nib_lo (rom_lo),
        .rgb    (rgb)
    );

    // Register the pixel result; valid clears on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spr_valid <= 1'b0;
            spr_cidx  <= '0;
            spr_rgb   <= '0;
        end else begin
            spr_valid <= pix_valid && in_window;
            spr_cidx  <= cidx;
            spr_rgb   <= rgb;
        end
    end
endmodule

// File: rtl/sprite_frame_buffer.sv
// Top: two sprite attribute banks with a once-per-frame role swap, plus the
// sprite pixel colour path. The bank just displayed is cleared at the swap,
// and a processor write in the swap cycle lands after that clear.
// Assumes line_done pulses once per scanline.
module sprite_frame_buffer
    import sprite_fb_pkg::*;
#(
    parameter int AW        = 8,
    parameter int DW        = 8,
    parameter int LW        = 9,
    parameter int SWAP_LINE = 239,
    parameter int XW        = 8,
    parameter int SCREEN_W  = 256,
    parameter int CLIP_L    = 8,
    parameter int CLIP_R    = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    cpu_addr,
    input  logic [DW-1:0]    cpu_wdata,
    input  logic             cpu_we,
    output logic [DW-1:0]    cpu_rdata,
    input  logic [AW-1:0]    rend_addr,
    output logic [DW-1:0]    rend_data,
    input  logic [LW-1:0]    line_num,
    input  logic             line_done,
    input  logic             pix_valid,
    input  logic [XW-1:0]    pix_x,
    input  logic [2:0]       pix_grp,
    input  logic [1:0]       pix_val,
    output logic [4:0]       pal_addr,
    input  logic [5:0]       pal_data,
    output logic [7:0]       rom_addr,
    input  logic [3:0]       rom_hi,
    input  logic [3:0]       rom_lo,
    output logic             spr_valid,
    output logic [6:0]       spr_cidx,
    output logic [RGB_W-1:0] spr_rgb
);
    localparam int NBANK = 2;

    logic          disp_sel;
    logic          swap;
    logic [DW-1:0] bank_rd [NBANK];

    // Swap trigger at the end of the last visible scanline.
    assign swap = line_done && (int'(line_num) == SWAP_LINE);

    // Role register: index of the display bank.
    always_ff @(posedge clk) begin
        if (!rst_n)    disp_sel <= 1'b0;
        else if (swap) disp_sel <= ~disp_sel;
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic          is_disp;
        logic          clr_b;
        logic          we_b;
        logic [AW-1:0] ra_b;

        // Per-bank control: clear and write target follow the swap.
        always_comb begin
            is_disp = (disp_sel == 1'(b));
            clr_b   = swap && is_disp;
            we_b    = cpu_we && (swap ? is_disp : !is_disp);
            ra_b    = is_disp ? rend_addr : cpu_addr;
        end

        sprbuf_bank #(.AW(AW), .DW(DW)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr_b),
            .we    (we_b),
            .waddr (cpu_addr),
            .wdata (cpu_wdata),
            .raddr (ra_b),
            .rdata (bank_rd[b])
        );
    end

    // Route bank read data to the two ports by current role.
    always_comb begin
        rend_data = bank_rd[disp_sel];
        cpu_rdata = bank_rd[~disp_sel];
    end

    spr_pixel_path #(
        .XW(XW), .SCREEN_W(SCREEN_W), .CLIP_L(CLIP_L), .CLIP_R(CLIP_R)
    ) u_pix (
        .clk       (clk),
        .rst_n     (rst_n),
        .pix_valid (pix_valid),
        .pix_x     (pix_x),
        .pix_grp   (pix_grp),
        .pix_val   (pix_val),
        .pal_addr  (pal_addr),
        .pal_data  (pal_data),
        .rom_addr  (rom_addr),
        .rom_hi    (rom_hi),
        .rom_lo    (rom_lo),
        .spr_valid (spr_valid),
        .spr_cidx  (spr_cidx),
        .spr_rgb   (spr_rgb)
    );
endmodule

// File: rtl/sprite_frame_buffer_chk.sv
// Checker for sprite_frame_buffer: role swap timing, clear after swap,
// clipping and sprite colour bank. Bound to every instance of the top.
module sprite_frame_buffer_chk #(
    parameter int AW        = 8,
    parameter int DW        = 8,
    parameter int LW        = 9,
    parameter int SWAP_LINE = 239,
    parameter int XW        = 8,
    parameter int X_LO      = 8,
    parameter int X_HI      = 250
) (
    input logic          clk,
    input logic          rst_n,
    input logic          disp_sel,
    input logic          line_done,
    input logic [LW-1:0] line_num,
    input logic          cpu_we,
    input logic [DW-1:0] cpu_rdata,
    input logic          pix_valid,
    input logic [XW-1:0] pix_x,
    input logic          spr_valid,
    input logic [6:0]    spr_cidx
);
    logic trig;
    assign trig = line_done && (int'(line_num) == SWAP_LINE);

    // R2
    swap_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> (disp_sel != $past(disp_sel)));

    // R2
    no_swap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trig |=> $stable(disp_sel));

    // R3
    clear_after_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && !cpu_we) |=> (cpu_rdata == '0));

    // R6
    clip_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && ((int'(pix_x) < X_LO) || (int'(pix_x) >= X_HI))) |=> !spr_valid);

    // R6
    idle_pixel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |=> !spr_valid);

    // R7
    upper_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spr_valid |-> spr_cidx[6]);
endmodule

bind sprite_frame_buffer sprite_frame_buffer_chk #(
    .AW(AW), .DW(DW), .LW(LW), .SWAP_LINE(SWAP_LINE), .XW(XW),
    .X_LO(CLIP_L), .X_HI(SCREEN_W - CLIP_R)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .disp_sel  (disp_sel),
    .line_done (line_done),
    .line_num  (line_num),
    .cpu_we    (cpu_we),
    .cpu_rdata (cpu_rdata),
    .pix_valid (pix_valid),
    .pix_x     (pix_x),
    .spr_valid (spr_valid),
    .spr_cidx  (spr_cidx)
);

// File: tb/sprite_frame_buffer_test.sv
`timescale 1ns/100ps
module sprite_frame_buffer_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  cpu_addr, cpu_wdata, cpu_rdata, rend_addr, rend_data;
    logic        cpu_we;
    logic [8:0]  line_num;
    logic        line_done;
    logic        pix_valid;
    logic [7:0]  pix_x;
    logic [2:0]  pix_grp;
    logic [1:0]  pix_val;
    logic [4:0]  pal_addr;
    logic [5:0]  pal_data;
    logic [7:0]  rom_addr;
    logic [3:0]  rom_hi, rom_lo;
    logic        spr_valid;
    logic [6:0]  spr_cidx;
    logic [23:0] spr_rgb;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    sprite_frame_buffer uut (
        .clk(clk), .rst_n(rst_n),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_we(cpu_we), .cpu_rdata(cpu_rdata),
        .rend_addr(rend_addr), .rend_data(rend_data),
        .line_num(line_num), .line_done(line_done),
        .pix_valid(pix_valid), .pix_x(pix_x), .pix_grp(pix_grp), .pix_val(pix_val),
        .pal_addr(pal_addr), .pal_data(pal_data),
        .rom_addr(rom_addr), .rom_hi(rom_hi), .rom_lo(rom_lo),
        .spr_valid(spr_valid), .spr_cidx(spr_cidx), .spr_rgb(spr_rgb)
    );

    // Bench-side palette and ROM contents, computed arithmetically.
    function automatic logic [5:0] pal_f(input logic [4:0] a);
        return 6'((int'(a) * 5 + 1) & 63);
    endfunction
    function automatic logic [7:0] rom_f(input logic [7:0] a);
        return 8'((int'(a) * 37 + 11) & 255);
    endfunction
    function automatic logic [7:0] pat_f(input int a, input int s);
        return 8'((a * 7 + s) & 255);
    endfunction

    always_comb begin
        pal_data = pal_f(pal_addr);
        {rom_hi, rom_lo} = rom_f(rom_addr);
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cpu_write(input int a, input logic [7:0] d);
        cpu_addr = 8'(a); cpu_wdata = d; cpu_we = 1'b1;
        @(negedge clk);
        cpu_we = 1'b0;
    endtask

    task automatic end_line(input int ln);
        line_num = 9'(ln); line_done = 1'b1;
        @(negedge clk);
        line_done = 1'b0;
    endtask

    // Check both ports over all addresses against expected functions.
    task automatic sweep(input string req, input int cpu_seed, input int rend_seed);
        for (int a = 0; a < 256; a++) begin
            cpu_addr = 8'(a); rend_addr = 8'(a);
            #0.1;
            chk({req, " cpu"}, 32'(cpu_rdata), (cpu_seed < 0) ? 32'h0 : 32'(pat_f(a, cpu_seed)));
            chk({req, " rend"}, 32'(rend_data), (rend_seed < 0) ? 32'h0 : 32'(pat_f(a, rend_seed)));
        end
    endtask

    initial begin
        #(5.0 * 200000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cpu_addr = '0; cpu_wdata = '0; cpu_we = 1'b0; rend_addr = '0;
        line_num = '0; line_done = 1'b0; pix_valid = 1'b0; pix_x = '0; pix_grp = '0; pix_val = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R5: reset state, both ports read zero everywhere
        sweep("R5", -1, -1);
        chk("R5 valid", 32'(spr_valid), 32'h0);

        // R1: fill pending bank; renderer must still see zeros
        for (int a = 0; a < 256; a++) cpu_write(a, pat_f(a, 3));
        sweep("R1", 3, -1);

        // R2: end of a non-swap line and a strobe-less 239 change nothing
        end_line(100);
        line_num = 9'd239; @(negedge clk);
        sweep("R2", 3, -1);

        // R3: swap, pending now cleared and renderer sees old pending data
        end_line(239);
        sweep("R3", -1, 3);

        // R4: fill again, then swap with a simultaneous write at address 5
        for (int a = 0; a < 256; a++) cpu_write(a, pat_f(a, 91));
        line_num = 9'd239; line_done = 1'b1;
        cpu_addr = 8'd5; cpu_wdata = 8'hAA; cpu_we = 1'b1;
        @(negedge clk);
        line_done = 1'b0; cpu_we = 1'b0;
        for (int a = 0; a < 256; a++) begin
            cpu_addr = 8'(a); rend_addr = 8'(a);
            #0.1;
            chk("R4 cpu", 32'(cpu_rdata), (a == 5) ? 32'hAA : 32'h0);
            chk("R4 rend", 32'(rend_data), 32'(pat_f(a, 91)));
        end

        // R6..R10: sweep every x, group and pixel value
        for (int x = 0; x < 256; x++) begin
            for (int g = 0; g < 8; g++) begin
                for (int p = 0; p < 4; p++) begin
                    logic [4:0] pa;
                    logic [6:0] ci;
                    logic [7:0] rb;
                    logic [2:0] r3, g3;
                    logic [1:0] b2;
                    logic [23:0] rgb;
                    logic vin;
                    vin = ((x + g + p) % 5) != 0;
                    pix_valid = vin; pix_x = 8'(x); pix_grp = 3'(g); pix_val = 2'(p);
                    pa = 5'((g * 4) | p);
                    ci = {1'b1, pal_f(pa)};
                    rb = rom_f({1'b1, ci});
                    r3 = {rb[0], rb[1], rb[2]};
                    g3 = {rb[3], rb[4], rb[5]};
                    b2 = {rb[6], rb[7]};
                    rgb = {r3, r3, r3[2:1], g3, g3, g3[2:1], b2, b2, b2, b2};
                    #0.1;
                    if (p == 0) begin
                        chk("R7 pal_addr", 32'(pal_addr), 32'(pa));
                        chk("R8 rom_addr", 32'(rom_addr), 32'({1'b1, ci}));
                    end
                    @(negedge clk);
                    chk("R6 valid", 32'(spr_valid), 32'(vin && x >= 8 && x < 250));
                    if (vin && x >= 8 && x < 250) begin
                        chk("R7 cidx", 32'(spr_cidx), 32'(ci));
                        chk("R9 R10 rgb", spr_rgb, 32'(rgb));
                    end
                end
            end
        end
        pix_valid = 1'b0;
        @(negedge clk);
        chk("R6 idle", 32'(spr_valid), 32'h0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule